// File: doc/BRIEF.md
# Byte Serial Peripheral Interface Controller

This block is an SPI controller for an 8-bit CPU register bus. It has three registers: a control register, a status register and a data register. A write to the data register loads the shifter and, in master mode, starts a transfer of one byte. The block makes SCK from the system clock through a prescaler with a selectable rate and a double-speed option. It supports both clock polarities, both clock phases and both bit orders. In slave mode the external SCK, slave-select and serial input first pass through a two-flop synchronizer. Shifting then follows the edges found in the system clock domain.

At the end of a transfer the block sets a completion flag. With the interrupt enable bit set, this flag drives the interrupt line. A data write made while a transfer is running is dropped and sets a collision flag. Two things clear the flags: an interrupt acknowledge, or a status read that sees a flag set followed by any access to the data register. If slave-select goes low while the block is an enabled master, the block aborts the transfer, falls back to slave mode and sets the completion flag.

Top module: `spi_ctrl`

## Requirements
- R1: In master mode with the block enabled, a write to the data register (address 2) starts a transfer. When the transfer ends, a data register read returns the byte received on sdi_i. The byte written appears on sdo_o, most significant bit first, when control bit 5 is 0.
- R2: With control bit 5 (bit order) at 1, both the transmitted byte and the received byte travel least significant bit first.
- R3: Control bit 3 sets the SCK idle level. With control bit 2 at 0, data is sampled on the leading SCK edge and changed on the trailing edge. With control bit 2 at 1, data is changed on the leading edge and sampled on the trailing edge.
- R4: Control bits 1:0 select the rate. With status bit 0 (double speed) at 0, the SCK period is 4, 16, 64 or 128 clocks for rates 0 to 3. With status bit 0 at 1, it is 2, 8, 32 or 64 clocks. The completion flag is readable exactly 8 SCK periods after the clock edge that takes the data write.
- R5: The completion flag is status bit 7 and is set when a transfer ends. irq_o is high while that flag and control bit 7 (interrupt enable) are both set.
- R6: A pulse on irq_ack_i clears the completion flag.
- R7: A status read (address 1, rd_i) that sees a flag set, followed by a data register read or write, clears that flag. A collision seen this way clears both flags. A data access that is not preceded by such a status read, or an access to another register in between, clears nothing.
- R8: A data write during a transfer sets status bit 6 (collision). The write is ignored: the byte being shifted out and the byte received are unchanged.
- R9: When the block is enabled as a master (control bits 6 and 4 at 1) and ss_ni goes low, the transfer is aborted, control bit 4 reads 0, SCK returns to idle and the completion flag is set.
- R10: After reset all registers and irq_o read 0. Status bits 5 to 1 always read 0, status bit 0 is read/write, and a write to status bits 7 and 6 has no effect.
- R11: In slave mode (control bit 6 at 1, bit 4 at 0), with ss_ni low, the block shifts on the edges of sck_i. It presents the loaded byte on sdo_o, receives the byte from sdi_i and sets the completion flag after 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effects only) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the completion flag |
| sck_i | input | 1 | Serial clock in, used in slave mode |
| sck_o | output | 1 | Serial clock out, used in master mode |
| ss_ni | input | 1 | Slave select, active low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
A wrong edge count or a wrong prescaler setting shows up at once as a completion interrupt that comes early or late against the 8-period budget. A bit-order or phase fault shows up as a corrupted byte, either in the serial stream captured off sdo_o or in the data register after the transfer. A fault in the flag-clear arming stays hidden until the next data access. At that access the status register either still holds a flag or has lost one, so each clear path is checked on the cycle after its access. A mode-fault path that fails to drop the master bit is visible in the control register within four clocks of slave-select going low.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;
endpackage

// File: rtl/spi_ctrl_sync.sv
module spi_ctrl_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_ctrl_clkdiv.sv
module spi_ctrl_clkdiv #(
  parameter int CNT_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  input  logic       dbl_i,
  output logic       tick_o
);
  logic [2:0]       hexp;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;

  // half-period exponent: divisors 4/16/64/128, halved by double speed
  always_comb begin
    unique case (rate_i)
      2'd0:    hexp = 3'd1;
      2'd1:    hexp = 3'd3;
      2'd2:    hexp = 3'd5;
      default: hexp = 3'd6;
    endcase
    if (dbl_i) hexp = hexp - 3'd1;
    lim = CNT_W'((32'd1 << hexp) - 32'd1);
  end

  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  p_tick_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && lim != '0) |=> !tick_o);
endmodule

// File: rtl/spi_ctrl_shift.sv
module spi_ctrl_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          abort_i,
  input  logic          lead_i,
  input  logic          trail_i,
  input  logic          cpha_i,
  input  logic          lsb_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          done_o,
  output logic          active_o,
  output logic [DW-1:0] rx_o
);
  localparam int EC = 2 * DW;
  localparam int EW = $clog2(EC);

  logic [DW-1:0] sr_q, rx_q;
  logic [EW-1:0] cnt_q;
  logic          smp_q;
  logic          last;

  function automatic logic [DW-1:0] shin(logic [DW-1:0] v, logic b, logic lsb);
    return lsb ? {b, v[DW-1:1]} : {v[DW-2:0], b};
  endfunction

  assign last     = trail_i && (cnt_q == EW'(EC - 1));
  assign done_o   = last;
  assign active_o = (cnt_q != '0);
  assign sdo_o    = lsb_i ? sr_q[0] : sr_q[DW-1];
  assign rx_o     = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (abort_i || load_i) begin
      cnt_q <= '0;
    end else if (lead_i || trail_i) begin
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      rx_q  <= '0;
      smp_q <= 1'b0;
    end else if (load_i) begin
      sr_q <= load_data_i;
    end else if (!abort_i) begin
      if (!cpha_i) begin
        if (lead_i)  smp_q <= sdi_i;
        if (trail_i) sr_q  <= shin(sr_q, smp_q, lsb_i);
        if (last)    rx_q  <= shin(sr_q, smp_q, lsb_i);
      end else begin
        if (lead_i && cnt_q != '0) sr_q <= shin(sr_q, smp_q, lsb_i);
        if (trail_i) smp_q <= sdi_i;
        if (last) begin
          sr_q <= shin(sr_q, sdi_i, lsb_i);
          rx_q <= shin(sr_q, sdi_i, lsb_i);
        end
      end
    end
  end

  p_load_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (cnt_q == '0));
  p_abort_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (cnt_q == '0));
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_ctrl_pkg::*;
#(
  parameter int DW      = 8,
  parameter int SYNC_ST = 2,
  parameter int DIV_W   = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  input  logic          irq_ack_i,
  input  logic          sck_i,
  output logic          sck_o,
  input  logic          ss_ni,
  input  logic          sdi_i,
  output logic          sdo_o
);
  ctrl_t         ctrl_q;
  logic          dbl_q, done_q, coll_q, arm_done_q, arm_coll_q;
  logic          run_q, lvl_q, sck_p_q;
  logic          ss_s, sck_s, sdi_s;
  logic          tick, m_lead, m_trail, s_lead, s_trail, s_en;
  logic          eng_done, eng_active, eng_sdi, abort;
  logic [DW-1:0] rx;
  logic          data_acc, data_wr, stat_rd, busy, start, fault;
  logic          done_set, coll_set, flag_clr;
  logic [DW-1:0] stat_rd_val;

  spi_ctrl_sync #(.STAGES(SYNC_ST), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sck_i, sdi_i}),
    .q_o   ({ss_s, sck_s, sdi_s})
  );

  spi_ctrl_clkdiv #(.CNT_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .rate_i(ctrl_q.rate),
    .dbl_i (dbl_q),
    .tick_o(tick)
  );

  // bus decode
  assign data_acc = (rd_i || wr_i) && (addr_i == ADDR_DATA);
  assign data_wr  = wr_i && (addr_i == ADDR_DATA);
  assign stat_rd  = rd_i && (addr_i == ADDR_STAT);
  assign busy     = run_q || eng_active;
  assign start    = data_wr && !busy && ctrl_q.enable && ctrl_q.master;
  assign fault    = ctrl_q.enable && ctrl_q.master && !ss_s;

  // master clock phase
  assign m_lead  = run_q && tick && !lvl_q;
  assign m_trail = run_q && tick &&  lvl_q;
  assign sck_o   = ctrl_q.cpol ^ lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      lvl_q <= 1'b0;
    end else if (fault || !ctrl_q.enable || !ctrl_q.master) begin
      run_q <= 1'b0;
      lvl_q <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1;
      lvl_q <= 1'b0;
    end else begin
      if (tick) lvl_q <= ~lvl_q;
      if (eng_done) run_q <= 1'b0;
    end
  end

  // slave edge detect on synchronized clock
  assign s_en    = ctrl_q.enable && !ctrl_q.master && !ss_s;
  assign s_lead  = s_en && (ctrl_q.cpol ? (sck_p_q && !sck_s) : (!sck_p_q && sck_s));
  assign s_trail = s_en && (ctrl_q.cpol ? (!sck_p_q && sck_s) : (sck_p_q && !sck_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_p_q <= 1'b0;
    else         sck_p_q <= sck_s;
  end

  assign abort   = fault || !ctrl_q.enable || (!ctrl_q.master && ss_s);
  assign eng_sdi = ctrl_q.master ? sdi_i : sdi_s;

  spi_ctrl_shift #(.DW(DW)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (data_wr && !busy),
    .load_data_i(wdata_i),
    .abort_i    (abort),
    .lead_i     (ctrl_q.master ? m_lead : s_lead),
    .trail_i    (ctrl_q.master ? m_trail : s_trail),
    .cpha_i     (ctrl_q.cpha),
    .lsb_i      (ctrl_q.lsb_first),
    .sdi_i      (eng_sdi),
    .sdo_o      (sdo_o),
    .done_o     (eng_done),
    .active_o   (eng_active),
    .rx_o       (rx)
  );

  // flags
  assign done_set = eng_done || fault;
  assign coll_set = data_wr && busy;
  assign flag_clr = data_acc && (arm_done_q || arm_coll_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q     <= 1'b0;
      coll_q     <= 1'b0;
      arm_done_q <= 1'b0;
      arm_coll_q <= 1'b0;
    end else begin
      if (done_set)                        done_q <= 1'b1;
      else if (irq_ack_i || flag_clr)      done_q <= 1'b0;
      if (coll_set)                        coll_q <= 1'b1;
      else if (data_acc && arm_coll_q)     coll_q <= 1'b0;
      if (stat_rd) begin
        arm_done_q <= done_q;
        arm_coll_q <= coll_q;
      end else if (wr_i || rd_i) begin
        arm_done_q <= 1'b0;
        arm_coll_q <= 1'b0;
      end
    end
  end

  // control and double-speed registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      dbl_q  <= 1'b0;
    end else begin
      if (wr_i && addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata_i[7:0]);
      if (fault) ctrl_q.master <= 1'b0;
      if (wr_i && addr_i == ADDR_STAT) dbl_q <= wdata_i[0];
    end
  end

  always_comb begin
    stat_rd_val       = '0;
    stat_rd_val[DW-1] = done_q;
    stat_rd_val[DW-2] = coll_q;
    stat_rd_val[0]    = dbl_q;
    unique case (addr_i)
      ADDR_CTRL: rdata_o = DW'(ctrl_q);
      ADDR_STAT: rdata_o = stat_rd_val;
      ADDR_DATA: rdata_o = rx;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = ctrl_q.irq_en && done_q;

  p_done_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set |=> done_q);
  p_ack_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !done_set) |=> !done_q);
  p_coll_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_set |=> coll_q);
  p_fault_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> (!ctrl_q.master && !run_q));
  p_arm_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && arm_coll_q && !done_set && !coll_set) |=> (!done_q && !coll_q));
endmodule

// File: tb/sim_spi_ctrl.sv
module sim_spi_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr = 1'b0, rd = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, sck_o, sdo;
  logic       sck_i = 1'b0, ss_n = 1'b1, sdi = 1'b0;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  spi_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .irq_ack_i(ack),
    .sck_i(sck_i), .sck_o(sck_o), .ss_ni(ss_n), .sdi_i(sdi), .sdo_o(sdo)
  );

  // bench slave model on master pins
  bit         mdl_on = 1'b0;
  logic       m_cpol, m_cpha, m_lsb, sdo_d;
  logic [7:0] m_pat, m_rx;
  int         m_bit, m_drv;

  always @(negedge clk) sdo_d <= sdo;

  task automatic mdl_drive();
    if (m_drv < 8) begin
      sdi = m_lsb ? m_pat[m_drv] : m_pat[7-m_drv];
      m_drv++;
    end
  endtask

  task automatic mdl_cap();
    if (m_bit < 8) begin
      if (m_lsb) m_rx[m_bit] = sdo_d;
      else       m_rx[7-m_bit] = sdo_d;
      m_bit++;
    end
  endtask

  always @(sck_o) begin
    if (mdl_on) begin
      if (sck_o != m_cpol) begin
        if (!m_cpha) mdl_cap(); else mdl_drive();
      end else begin
        if (!m_cpha) mdl_drive(); else mdl_cap();
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // ctrl, dbl, tx, rx pattern, expected cycles write->irq
  typedef struct packed {
    logic [7:0]  ctrl;
    logic        dbl;
    logic [7:0]  tx;
    logic [7:0]  pat;
    logic [15:0] cyc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'hD0, 1'b0, 8'hA5, 8'h3C, 16'd32},
    '{8'hD5, 1'b0, 8'h96, 8'hF0, 16'd128},
    '{8'hDA, 1'b1, 8'h01, 8'h80, 16'd256},
    '{8'hFC, 1'b1, 8'h1E, 8'h47, 16'd16},
    '{8'hF3, 1'b0, 8'h82, 8'h6D, 16'd1024},
    '{8'hD3, 1'b1, 8'hFF, 8'h00, 16'd512}
  };

  task automatic start_master(vec_t v);
    bus_wr(2'd0, v.ctrl);
    bus_wr(2'd1, {7'd0, v.dbl});
    wait_clk(3);
    m_cpol = v.ctrl[3]; m_cpha = v.ctrl[2]; m_lsb = v.ctrl[5];
    m_pat = v.pat; m_rx = 8'h00; m_bit = 0; m_drv = 0;
    if (!m_cpha) mdl_drive();
    mdl_on = 1'b1;
    bus_wr(2'd2, v.tx);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 5000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic clear_flags();
    bus_rd(2'd1);
    bus_rd(2'd2);
  endtask

  initial begin
    logic [7:0] v;
    int n;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R10 reset state
    peek(2'd0, v); check("R10 ctrl reset", v, 8'h00);
    peek(2'd1, v); check("R10 status reset", v, 8'h00);
    check("R10 irq reset", irq, 0);
    check("R10 sck idle", sck_o, 0);
    bus_wr(2'd1, 8'hFF);
    peek(2'd1, v); check("R10 status reserved/ro bits", v, 8'h01);
    bus_wr(2'd1, 8'h00);

    // R1..R5 vector walk
    for (int i = 0; i < NV; i++) begin
      start_master(VECS[i]);
      wait_irq(n);
      check($sformatf("R4 R5 cycles to irq v%0d", i), n, VECS[i].cyc);
      wait_clk(2);
      mdl_on = 1'b0;
      peek(2'd2, v); check($sformatf("R1 R2 R3 rx byte v%0d", i), v, VECS[i].pat);
      check($sformatf("R1 R2 R3 tx stream v%0d", i), m_rx, VECS[i].tx);
      peek(2'd1, v); check($sformatf("R5 status set v%0d", i), v, {7'h40, VECS[i].dbl});
      clear_flags();
      peek(2'd1, v); check($sformatf("R7 cleared v%0d", i), v, {7'd0, VECS[i].dbl});
      check($sformatf("R5 irq low v%0d", i), irq, 0);
    end

    // R7 data access without arming does not clear
    start_master(VECS[0]);
    wait_irq(n);
    wait_clk(2); mdl_on = 1'b0;
    bus_rd(2'd2);
    peek(2'd1, v); check("R7 unarmed data read keeps flag", v, 8'h80);
    bus_rd(2'd1);
    bus_rd(2'd0);
    bus_rd(2'd2);
    peek(2'd1, v); check("R7 intervening access keeps flag", v, 8'h80);
    clear_flags();
    peek(2'd1, v); check("R7 armed clear", v, 8'h00);

    // R6 interrupt acknowledge
    start_master(VECS[3]);
    wait_irq(n);
    wait_clk(2); mdl_on = 1'b0;
    check("R6 irq raised", irq, 1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    peek(2'd1, v); check("R6 ack clears flag", v, 8'h01);
    check("R6 irq dropped", irq, 0);
    bus_wr(2'd1, 8'h00);

    // R8 collision
    start_master('{8'hD1, 1'b0, 8'h5C, 8'hA3, 16'd0});
    wait_clk(20);
    bus_wr(2'd2, 8'hFF);
    peek(2'd1, v); check("R8 collision flag mid transfer", v, 8'h40);
    wait_irq(n);
    wait_clk(2); mdl_on = 1'b0;
    peek(2'd2, v); check("R8 rx undisturbed", v, 8'hA3);
    check("R8 tx undisturbed", m_rx, 8'h5C);
    peek(2'd1, v); check("R8 both flags", v, 8'hC0);
    clear_flags();
    peek(2'd1, v); check("R7 R8 collision clear", v, 8'h00);

    // R9 mode fault
    bus_wr(2'd0, 8'hD1);
    bus_wr(2'd2, 8'h33);
    wait_clk(10);
    ss_n = 1'b0;
    wait_clk(4);
    peek(2'd1, v); check("R9 fault sets flag", v, 8'h80);
    peek(2'd0, v); check("R9 master bit dropped", v, 8'hC1);
    wait_clk(40);
    check("R9 sck idle after abort", sck_o, 0);
    check("R9 irq from fault", irq, 1);
    ss_n = 1'b1;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;

    // R11 slave transfer, mode 0, msb first
    begin
      logic [7:0] got, mpat;
      got = 8'h00; mpat = 8'hD2;
      bus_wr(2'd0, 8'h40);
      wait_clk(4);
      bus_wr(2'd2, 8'h6B);
      ss_n = 1'b0;
      wait_clk(6);
      for (int b = 7; b >= 0; b--) begin
        sdi = mpat[b];
        wait_clk(8);
        got[b] = sdo;
        sck_i = 1'b1;
        wait_clk(8);
        sck_i = 1'b0;
      end
      wait_clk(6);
      ss_n = 1'b1;
      wait_clk(4);
      check("R11 slave tx stream", got, 8'h6B);
      peek(2'd2, v); check("R11 slave rx byte", v, 8'hD2);
      peek(2'd1, v); check("R11 slave done flag", v, 8'h80);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule